// File: doc/BRIEF.md
# Video memory port address sequencer

This block lets a CPU with a byte-wide register bus reach a video memory organised as 16-bit words. Software first loads a control byte and a 16-bit word address (sent as two separate bytes). It then streams data through two byte-wide data registers, one for each half of the word. Every data write is passed to the memory at once, with a byte enable for the half it carries. After the access that software has chosen as the trigger, the word address moves forward by a selectable step. With this, software can fill rows, columns or larger strides of the memory without reloading the address.

Reads go through a one-word prefetch latch. Loading either address byte makes the block fetch the word at the new address into the latch. A read of the triggering data register returns the latched byte, advances the address, and then fetches the word at the new address. For tiled graphics, a remap mode rotates the low address bits on their way to the memory. A linear run of accesses then visits one bit-plane row of each tile in turn, while the internal counter still counts linearly.

Top module: `vram_port_seq`

## Requirements
- R1: After synchronous reset the word address and the control byte are zero, the prefetch latch holds zero, and `mem_addr` reads 0.
- R2: A write with `reg_sel`=1 replaces address bits 7:0 and a write with `reg_sel`=2 replaces bits 15:8. Both take effect on the next cycle.
- R3: A write with `reg_sel`=0 loads the control byte. Bit 7 is the trigger select, bits 3:2 are the remap mode and bits 1:0 are the step select. Bits 6:4 have no effect.
- R4: With trigger select 0, a low-byte data write or read (`reg_sel`=3) advances the address after the access. A high-byte access (`reg_sel`=4) leaves the address unchanged.
- R5: With trigger select 1, a high-byte data write or read (`reg_sel`=4) advances the address. A low-byte access leaves it unchanged.
- R6: Step select 0 advances the address by 1 and step select 1 by 32. Step selects 2 and 3 both advance it by 128. The address wraps at 16 bits.
- R7: Remap mode 0 presents the counter unchanged. Modes 1, 2 and 3 present `{a[15:K+3], a[K-1:0], a[K+2:K]}` with K = 5, 6, 7, so that successive step-1 accesses move by 8 through runs of 32, 64 or 128. The counter itself stays linear.
- R8: After either address byte is written, or after a triggering read, the prefetch latch is reloaded from the memory word at the (new) address. `reg_rdata` returns latch bits 7:0 when `reg_sel`=3 and bits 15:8 when `reg_sel`=4.
- R9: A low data write asserts `mem_we_lo` with the byte on `mem_wdata[7:0]`. A high data write asserts `mem_we_hi` with the byte on `mem_wdata[15:8]`. Both happen in the same cycle as the write, at the current `mem_addr`, and the two enables are never both high.
- R10: Writing the non-triggering byte and then the triggering byte stores a full word at one address and advances the address only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | CPU register write strobe |
| reg_re | input | 1 | CPU register read strobe (ignored when reg_we is high) |
| reg_sel | input | 3 | Register select: 0 control, 1 address low, 2 address high, 3 data low, 4 data high |
| reg_wdata | input | 8 | CPU write byte |
| reg_rdata | output | 8 | Selected byte of the prefetch latch |
| mem_addr | output | 16 | Remapped word address toward the memory |
| mem_we_lo | output | 1 | Write enable for memory bits 7:0 |
| mem_we_hi | output | 1 | Write enable for memory bits 15:8 |
| mem_wdata | output | 16 | Write data, the CPU byte on both halves |
| mem_re | output | 1 | Prefetch read strobe; mem_rdata is captured at the end of this cycle |
| mem_rdata | input | 16 | Word read from memory at mem_addr |

## Verification
Directed sequences cover each trigger setting with lone writes and with write pairs in both orders. A pair that advances twice, or a lone byte that fails to advance, shows up in the final address and in the stored word. Each step select is run from a known address, and each remap mode is run over a full run of its length. The address seen after one access and after a complete run separates a correct rotation from a shifted or mirrored one. A long random mix of control, address, write and read traffic is then checked against a bench model, on every read value and on every presented address. This catches prefetch loads that are missed or taken from a stale address, and it ends with a comparison of the whole memory.

// File: rtl/vps_pkg.sv
package vps_pkg;

    localparam int VPS_AW = 16;
    localparam int VPS_DW = 16;
    localparam int VPS_BW = 8;

    typedef enum logic [1:0] {
        REMAP_NONE = 2'd0,
        REMAP_P2   = 2'd1,
        REMAP_P4   = 2'd2,
        REMAP_P8   = 2'd3
    } remap_e;

    typedef enum logic [1:0] {
        STEP_ONE  = 2'd0,
        STEP_ROW  = 2'd1,
        STEP_BIGA = 2'd2,
        STEP_BIGB = 2'd3
    } step_e;

    typedef struct packed {
        logic       hi_trig;
        logic [2:0] spare;
        remap_e     remap;
        step_e      step;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_CTRL    = 3'd0,
        SEL_ADDR_LO = 3'd1,
        SEL_ADDR_HI = 3'd2,
        SEL_DATA_LO = 3'd3,
        SEL_DATA_HI = 3'd4
    } sel_e;

    function automatic logic [VPS_BW-1:0] step_amount(input step_e s);
        case (s)
            STEP_ONE: step_amount = 8'd1;
            STEP_ROW: step_amount = 8'd32;
            default:  step_amount = 8'd128;
        endcase
    endfunction

    function automatic ctrl_t ctrl_from_byte(input logic [VPS_BW-1:0] b);
        ctrl_t c;
        c.hi_trig = b[7];
        c.spare   = 3'b000;
        c.remap   = remap_e'(b[3:2]);
        c.step    = step_e'(b[1:0]);
        return c;
    endfunction

endpackage

// File: rtl/vps_addr_unit.sv
module vps_addr_unit
    import vps_pkg::*;
#(
    parameter int AW = VPS_AW,
    parameter int BW = VPS_BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [BW-1:0] wbyte,
    input  logic          advance,
    input  logic [BW-1:0] step,
    output logic [AW-1:0] cnt
);
    localparam int HI_W = AW - BW;

    logic [AW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ld_lo) begin
            cnt_q[BW-1:0] <= wbyte;
        end else if (ld_hi) begin
            cnt_q[AW-1:BW] <= wbyte[HI_W-1:0];
        end else if (advance) begin
            cnt_q <= cnt_q + {{HI_W{1'b0}}, step};
        end
    end

    assign cnt = cnt_q;

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> (cnt_q == '0));

    // R6
    advance_step_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !ld_lo && !ld_hi) |=> (cnt_q == $past(cnt_q) + {{HI_W{1'b0}}, $past(step)}));

    // R2
    load_low_chk: assert property (@(posedge clk) disable iff (rst)
        ld_lo |=> (cnt_q[BW-1:0] == $past(wbyte)) && (cnt_q[AW-1:BW] == $past(cnt_q[AW-1:BW])));

endmodule

// File: rtl/vps_remap.sv
module vps_remap
    import vps_pkg::*;
#(
    parameter int AW = VPS_AW
) (
    input  logic [AW-1:0] lin,
    input  remap_e        mode,
    output logic [AW-1:0] phys
);
    localparam int NMODES = 4;

    logic [AW-1:0] rot [NMODES];

    assign rot[0] = lin;

    for (genvar m = 1; m < NMODES; m++) begin : g_rot
        localparam int K = 4 + m;
        assign rot[m] = {lin[AW-1:K+3], lin[K-1:0], lin[K+2:K]};
    end

    assign phys = rot[2'(mode)];

endmodule

// File: rtl/vps_prefetch.sv
module vps_prefetch
    import vps_pkg::*;
#(
    parameter int DW = VPS_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fetch_req,
    input  logic [DW-1:0] mem_rdata,
    output logic          fetch_active,
    output logic [DW-1:0] word
);
    logic          pend_q;
    logic [DW-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            word_q <= '0;
        end else begin
            pend_q <= fetch_req;
            if (pend_q) begin
                word_q <= mem_rdata;
            end
        end
    end

    assign fetch_active = pend_q;
    assign word         = word_q;

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pend_q |=> $stable(word_q));

    // R8
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |=> (word_q == $past(mem_rdata)));

endmodule

// File: rtl/vram_port_seq.sv
module vram_port_seq
    import vps_pkg::*;
#(
    parameter int AW = VPS_AW,
    parameter int DW = VPS_DW,
    parameter int BW = VPS_BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic          reg_re,
    input  logic [2:0]    reg_sel,
    input  logic [BW-1:0] reg_wdata,
    output logic [BW-1:0] reg_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we_lo,
    output logic          mem_we_hi,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_re,
    input  logic [DW-1:0] mem_rdata
);
    ctrl_t         ctrl_q;
    logic [AW-1:0] cnt;
    logic [DW-1:0] latch;

    logic sel_ctrl, sel_alo, sel_ahi, sel_dlo, sel_dhi;
    logic rd_en;
    logic wr_lo, wr_hi, rd_lo, rd_hi;
    logic trig, trig_rd, nontrig_wr, fetch_req;

    always_comb begin
        sel_ctrl = (reg_sel == SEL_CTRL);
        sel_alo  = (reg_sel == SEL_ADDR_LO);
        sel_ahi  = (reg_sel == SEL_ADDR_HI);
        sel_dlo  = (reg_sel == SEL_DATA_LO);
        sel_dhi  = (reg_sel == SEL_DATA_HI);
        rd_en    = reg_re && !reg_we;
        wr_lo    = reg_we && sel_dlo;
        wr_hi    = reg_we && sel_dhi;
        rd_lo    = rd_en && sel_dlo;
        rd_hi    = rd_en && sel_dhi;
        if (ctrl_q.hi_trig) begin
            trig       = wr_hi || rd_hi;
            trig_rd    = rd_hi;
            nontrig_wr = wr_lo;
        end else begin
            trig       = wr_lo || rd_lo;
            trig_rd    = rd_lo;
            nontrig_wr = wr_hi;
        end
        fetch_req = (reg_we && (sel_alo || sel_ahi)) || trig_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (reg_we && sel_ctrl) begin
            ctrl_q <= ctrl_from_byte(reg_wdata);
        end
    end

    vps_addr_unit #(.AW(AW), .BW(BW)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .ld_lo   (reg_we && sel_alo),
        .ld_hi   (reg_we && sel_ahi),
        .wbyte   (reg_wdata),
        .advance (trig),
        .step    (step_amount(ctrl_q.step)),
        .cnt     (cnt)
    );

    vps_remap #(.AW(AW)) u_remap (
        .lin  (cnt),
        .mode (ctrl_q.remap),
        .phys (mem_addr)
    );

    vps_prefetch #(.DW(DW)) u_pref (
        .clk          (clk),
        .rst          (rst),
        .fetch_req    (fetch_req),
        .mem_rdata    (mem_rdata),
        .fetch_active (mem_re),
        .word         (latch)
    );

    assign mem_we_lo = wr_lo;
    assign mem_we_hi = wr_hi;
    assign mem_wdata = {reg_wdata, reg_wdata};
    assign reg_rdata = sel_dhi ? latch[DW-1:BW] : latch[BW-1:0];

    // R9
    we_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we_lo, mem_we_hi}));

    // R4
    nontrig_hold_chk: assert property (@(posedge clk) disable iff (rst)
        nontrig_wr |=> $stable(mem_addr));

    // R7
    remap_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.remap == REMAP_NONE) |-> (mem_addr == cnt));

    // R7
    remap_low_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.remap != REMAP_NONE) |-> (mem_addr[AW-1:10] == cnt[AW-1:10]));

endmodule

// File: tb/vram_port_seq_test.sv
module vram_port_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_N = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [2:0]  reg_sel = 3'd3;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [15:0] mem_addr;
    logic        mem_we_lo, mem_we_hi, mem_re;
    logic [15:0] mem_wdata, mem_rdata;

    logic [15:0] mem    [MEM_N];
    logic [15:0] shadow [MEM_N];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_addr;
    logic [7:0]  m_ctrl;
    logic [15:0] m_latch;

    always #(CLK_PERIOD/2) clk = ~clk;

    vram_port_seq uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_addr(mem_addr), .mem_we_lo(mem_we_lo), .mem_we_hi(mem_we_hi),
        .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] init_word(input int i);
        return 16'((i * 40503 + 4660) & 16'hFFFF);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_N; i++) mem[i] <= init_word(i);
        end else begin
            if (mem_we_lo) mem[mem_addr[11:0]][7:0]  <= mem_wdata[7:0];
            if (mem_we_hi) mem[mem_addr[11:0]][15:8] <= mem_wdata[15:8];
        end
    end

    assign mem_rdata = mem[mem_addr[11:0]];

    function automatic logic [15:0] phys(input logic [15:0] a, input logic [1:0] m);
        case (m)
            2'd1:    phys = (a & 16'hFF00) | ((a & 16'h001F) << 3) | ((a >> 5) & 16'h7);
            2'd2:    phys = (a & 16'hFE00) | ((a & 16'h003F) << 3) | ((a >> 6) & 16'h7);
            2'd3:    phys = (a & 16'hFC00) | ((a & 16'h007F) << 3) | ((a >> 7) & 16'h7);
            default: phys = a;
        endcase
    endfunction

    function automatic logic [15:0] step_of(input logic [1:0] s);
        return (s == 2'd0) ? 16'd1 : (s == 2'd1) ? 16'd32 : 16'd128;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // One register access in one cycle, then one idle cycle; starts and ends at a negedge.
    task automatic op(input logic we, input logic re, input logic [2:0] sel,
                      input logic [7:0] d, input string tag);
        logic [15:0] pa;
        logic trig, dsel, rd;
        reg_we = we; reg_re = re; reg_sel = sel; reg_wdata = d;
        #1;
        pa   = phys(m_addr, m_ctrl[3:2]);
        dsel = (sel == 3'd3) || (sel == 3'd4);
        trig = m_ctrl[7] ? (sel == 3'd4) : (sel == 3'd3);
        rd   = re && !we;
        if (rd && dsel)
            chk(tag, {24'd0, reg_rdata}, {24'd0, (sel == 3'd4) ? m_latch[15:8] : m_latch[7:0]});
        if (we) begin
            case (sel)
                3'd0: m_ctrl = d & 8'h8F;
                3'd1: m_addr[7:0] = d;
                3'd2: m_addr[15:8] = d;
                3'd3: shadow[pa[11:0]][7:0] = d;
                3'd4: shadow[pa[11:0]][15:8] = d;
                default: ;
            endcase
        end
        if (dsel && trig && (we || re))
            m_addr = m_addr + step_of(m_ctrl[1:0]);
        if ((we && (sel == 3'd1 || sel == 3'd2)) || (rd && dsel && trig))
            m_latch = shadow[phys(m_addr, m_ctrl[3:2])[11:0]];
        @(negedge clk);
        reg_we = 0; reg_re = 0;
        @(negedge clk);
        chk(tag, {16'd0, mem_addr}, {16'd0, phys(m_addr, m_ctrl[3:2])});
    endtask

    task automatic set_addr(input logic [15:0] a);
        op(1, 0, 3'd1, a[7:0], "R2 addr low");
        op(1, 0, 3'd2, a[15:8], "R2 addr high");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        int mism;
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEM_N; i++) shadow[i] = init_word(i);
        m_addr = 0; m_ctrl = 0; m_latch = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset addr", {16'd0, mem_addr}, 32'd0);
        chk("R1 reset latch", {24'd0, reg_rdata}, 32'd0);

        // R4 / R9 lone writes, low trigger
        op(1, 0, 3'd3, 8'h11, "R4 low write");
        chk("R9 low byte stored", {24'd0, mem[0][7:0]}, 32'h11);
        chk("R4 advanced by low", {16'd0, mem_addr}, 32'd1);
        op(1, 0, 3'd4, 8'h22, "R4 high write");
        chk("R9 high byte stored", {24'd0, mem[1][15:8]}, 32'h22);
        chk("R4 high no advance", {16'd0, mem_addr}, 32'd1);

        // R10 pair with low trigger
        set_addr(16'h0100);
        op(1, 0, 3'd4, 8'hAB, "R10 pair high");
        op(1, 0, 3'd3, 8'hCD, "R10 pair low");
        chk("R10 full word", {16'd0, mem[12'h100]}, 32'hABCD);
        chk("R10 single advance", {16'd0, mem_addr}, 32'h101);

        // R5 high trigger
        op(1, 0, 3'd0, 8'h80, "R5 ctrl");
        set_addr(16'h0200);
        op(1, 0, 3'd3, 8'h5A, "R5 low write");
        chk("R5 low no advance", {16'd0, mem_addr}, 32'h200);
        op(1, 0, 3'd4, 8'hA5, "R5 high write");
        chk("R5 high advance", {16'd0, mem_addr}, 32'h201);
        chk("R10 word high trigger", {16'd0, mem[12'h200]}, 32'hA55A);

        // R3 spare bits ignored
        op(1, 0, 3'd0, 8'h70, "R3 ctrl spare");
        op(1, 0, 3'd3, 8'h33, "R3 write");
        chk("R3 spare bits no effect", {16'd0, mem_addr}, 32'h202);

        // R6 steps
        op(1, 0, 3'd0, 8'h01, "R6 ctrl");
        op(1, 0, 3'd3, 8'h44, "R6 step32");
        chk("R6 step 32", {16'd0, mem_addr}, 32'h222);
        op(1, 0, 3'd0, 8'h02, "R6 ctrl");
        op(1, 0, 3'd3, 8'h45, "R6 step128a");
        chk("R6 step 128 sel2", {16'd0, mem_addr}, 32'h2A2);
        op(1, 0, 3'd0, 8'h03, "R6 ctrl");
        op(1, 0, 3'd3, 8'h46, "R6 step128b");
        chk("R6 step 128 sel3", {16'd0, mem_addr}, 32'h322);
        set_addr(16'hFFFF);
        op(1, 0, 3'd0, 8'h00, "R6 ctrl");
        op(1, 0, 3'd3, 8'h47, "R6 wrap");
        chk("R6 wrap", {16'd0, mem_addr}, 32'd0);

        // R7 remap runs
        op(1, 0, 3'd0, 8'h04, "R7 ctrl m1");
        set_addr(16'h0000);
        op(1, 0, 3'd3, 8'h50, "R7 m1");
        chk("R7 m1 first step", {16'd0, mem_addr}, 32'd8);
        for (int i = 0; i < 31; i++) op(1, 0, 3'd3, 8'(i), "R7 m1 run");
        chk("R7 m1 run end", {16'd0, mem_addr}, 32'd1);
        op(1, 0, 3'd0, 8'h08, "R7 ctrl m2");
        set_addr(16'h0000);
        for (int i = 0; i < 64; i++) op(1, 0, 3'd3, 8'(i), "R7 m2 run");
        chk("R7 m2 run end", {16'd0, mem_addr}, 32'd1);
        op(1, 0, 3'd0, 8'h0C, "R7 ctrl m3");
        set_addr(16'h0000);
        op(1, 0, 3'd3, 8'h60, "R7 m3");
        chk("R7 m3 first step", {16'd0, mem_addr}, 32'd8);
        for (int i = 0; i < 127; i++) op(1, 0, 3'd3, 8'(i), "R7 m3 run");
        chk("R7 m3 run end", {16'd0, mem_addr}, 32'd1);

        // R8 prefetch reads
        op(1, 0, 3'd0, 8'h00, "R8 ctrl");
        set_addr(16'h0100);
        op(0, 1, 3'd4, 8'h00, "R8 read high");
        chk("R8 high read no advance", {16'd0, mem_addr}, 32'h100);
        op(0, 1, 3'd3, 8'h00, "R8 read low");
        chk("R8 low read advance", {16'd0, mem_addr}, 32'h101);
        op(0, 1, 3'd3, 8'h00, "R8 read next word");

        // random mix
        for (int n = 0; n < 900; n++) begin
            int r;
            r = int'($urandom % 16);
            case (r)
                0:       op(1, 0, 3'd0, 8'($urandom), "R3 random ctrl");
                1:       op(1, 0, 3'd1, 8'($urandom), "R2 random addr low");
                2:       op(1, 0, 3'd2, 8'($urandom & 8'h0F), "R2 random addr high");
                3, 4, 5: op(1, 0, 3'd3, 8'($urandom), "R9 random low write");
                6, 7, 8: op(1, 0, 3'd4, 8'($urandom), "R9 random high write");
                9, 10, 11: op(0, 1, 3'd3, 8'h00, "R8 random low read");
                12, 13, 14: op(0, 1, 3'd4, 8'h00, "R8 random high read");
                default: op(0, 1, 3'd0, 8'h00, "R8 read of ctrl ignored");
            endcase
        end

        mism = 0;
        for (int i = 0; i < MEM_N; i++) if (mem[i] !== shadow[i]) mism++;
        chk("R10 memory image", 32'(mism), 32'd0);
        finish_up();
    end
endmodule